// File: doc/BRIEF.md
# Command Guard and Transfer Abort Controller

This block sits beside the command register of a tape formatter. Each time the controller loads a command with its start bit set, the block checks it. It merges the error bits into one composite error. If that error is present when the command arrives, the block refuses the command: the busy indication never rises, a pulse clears the start bit, and the attention flag is raised.

A command that is accepted marks the formatter busy until the motion logic reports the end of the operation. During that time the block watches the error bits and decides three things. For data transfers it drives an exception line and an end-of-block flag that stops the bus transfer. On writes it also issues a write-terminate request. At the defined milestones of an operation it raises attention.

The command's function class arrives already decoded on a 3-bit input with these codes:

- 0: control
- 1: erase, space or tape-mark write
- 2: rewind
- 3: read
- 4: write

The error bits are split by two parameter masks. Bits 3:0 are the class-B and illegal-function errors. Bits 7:4 are the data errors. Bits 15:8 count only toward the composite error.

Top module: `cmd_guard`

## Requirements
- R1: The composite error is the OR of all `err_bits`. A load with `cmd_go` high, while idle and with the composite error true, is refused: `busy` stays low and `go_clr` pulses for exactly one cycle after the load edge.
- R2: A load with `cmd_go` high, while idle and with no error, sets `busy` from the next cycle. `busy` falls in the cycle after the one in which `op_done` is sampled high.
- R3: A refused command pulses `attn_set` in the same cycle as `go_clr` and sets `attn`.
- R4: `attn_set` pulses the cycle after `op_done` for class 1. It pulses the cycle after acceptance of a class 2 command. A class 0 operation that ends with no error, no slave change and no end point gives no pulse.
- R5: `attn_set` pulses the cycle after `op_done` when any error bit, `ssc_evt` or `endpt_evt` was seen during the operation, including in the `op_done` cycle itself.
- R6: `exc` is high, with no register delay, whenever `busy` is high, the current class is 3 or 4, and the composite error is true.
- R7: `eob` is set the cycle after a class 3 or 4 command is refused for a pending error. It is also set when any error is present during the initiation phase of a transfer, which lasts from acceptance until `run_start` is sampled.
- R8: After `run_start`, `eob` is set by any bit in 3:0. It is set by a bit in 7:4 only while `abort_en` is high. Bits 15:8 alone never set it. `eob` is cleared only by the next accepted command.
- R9: On a write (class 4), `wr_end` is set together with any `eob` raised during the operation. On a read, `wr_end` stays low and `busy` stays high until `op_done`.
- R10: `attn` holds until `attn_clr`, and a set in the same cycle wins over the clear. A load while `busy` is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| err_bits | input | ERR_W | Error register bits |
| cmd_load | input | 1 | Command register load strobe |
| cmd_go | input | 1 | Start bit of the loaded command |
| cmd_class | input | 3 | Function class of the loaded command |
| abort_en | input | 1 | Abort transfer on data error enable |
| run_start | input | 1 | Transfer leaves initiation phase |
| op_done | input | 1 | Operation finished |
| ssc_evt | input | 1 | Slave status change seen |
| endpt_evt | input | 1 | Tape end point seen |
| attn_clr | input | 1 | Clear the attention flag |
| busy | output | 1 | Occupied indication |
| go_clr | output | 1 | Pulse clearing the start bit |
| attn_set | output | 1 | Pulse setting attention |
| attn | output | 1 | Attention flag |
| exc | output | 1 | Exception during transfer |
| eob | output | 1 | End-of-block to the bus |
| wr_end | output | 1 | Request to terminate a write |

## Verification
A wrong stored class or phase shows at the ports when it next matters. `exc` or `eob` misfires as soon as an error bit appears during a transfer. `attn_set` is missing or extra in the cycle after `op_done`. A lost per-operation event flag stays hidden until the end of the operation and then shows as a missing attention pulse. The bench compares every output against a behavioural model on every clock, so any divergence is caught in the cycle it reaches a port.

// File: rtl/cg_pkg.sv
// Shared types for the command guard: function classes and transfer phase.
package cg_pkg;
    typedef enum logic [2:0] {
        CLS_CTRL   = 3'd0,
        CLS_MOTION = 3'd1,
        CLS_REWIND = 3'd2,
        CLS_READ   = 3'd3,
        CLS_WRITE  = 3'd4
    } cls_e;

    typedef enum logic {
        PH_INIT = 1'b0,
        PH_XFER = 1'b1
    } phase_e;

    function automatic logic is_data(input logic [2:0] c);
        return (c == CLS_READ) || (c == CLS_WRITE);
    endfunction
endpackage

// File: rtl/cg_err_merge.sv
// Reduces the error register to a composite flag plus the class-B/illegal
// and data-error groups. Assumes the masks are disjoint.
module cg_err_merge #(
    parameter int          ERR_W   = 16,
    parameter logic [15:0] CB_MASK = 16'h000F,
    parameter logic [15:0] DT_MASK = 16'h00F0
) (
    input  logic [ERR_W-1:0] err_bits,
    output logic             any_err,
    output logic             cb_err,
    output logic             dt_err
);
    localparam logic [ERR_W-1:0] CBM = CB_MASK[ERR_W-1:0];
    localparam logic [ERR_W-1:0] DTM = DT_MASK[ERR_W-1:0];

    // Group reductions.
    always_comb begin
        any_err = |err_bits;
        cb_err  = |(err_bits & CBM);
        dt_err  = |(err_bits & DTM);
    end
endmodule

// File: rtl/cg_op_track.sv
// Tracks the current operation. It decides acceptance or refusal of a
// loaded command and records the class and phase. It also keeps flags for
// events seen during the operation. Assumes op_done comes only while busy.
module cg_op_track
    import cg_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cmd_load,
    input  logic       cmd_go,
    input  logic [2:0] cmd_class,
    input  logic       any_err,
    input  logic       run_start,
    input  logic       op_done,
    input  logic       ssc_evt,
    input  logic       endpt_evt,
    output logic       accept,
    output logic       reject,
    output logic       busy,
    output logic [2:0] cur_cls,
    output phase_e     phase,
    output logic       hit_err,
    output logic       hit_ssc,
    output logic       hit_ep
);
    // Command decision, evaluated in the load cycle.
    always_comb begin
        accept = cmd_load && cmd_go && !busy && !any_err;
        reject = cmd_load && cmd_go && !busy &&  any_err;
    end

    // Busy, class and phase registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy    <= 1'b0;
            cur_cls <= CLS_CTRL;
            phase   <= PH_INIT;
        end else if (accept) begin
            busy    <= 1'b1;
            cur_cls <= cmd_class;
            phase   <= PH_INIT;
        end else if (busy) begin
            if (op_done)
                busy <= 1'b0;
            if (run_start && phase == PH_INIT)
                phase <= PH_XFER;
        end
    end

    // Event flags collected over the operation.
    always_ff @(posedge clk) begin
        if (!rst_n || accept) begin
            hit_err <= 1'b0;
            hit_ssc <= 1'b0;
            hit_ep  <= 1'b0;
        end else if (busy) begin
            hit_err <= hit_err | any_err;
            hit_ssc <= hit_ssc | ssc_evt;
            hit_ep  <= hit_ep  | endpt_evt;
        end
    end
endmodule

// File: rtl/cg_attn.sv
// Attention logic: start-bit clear pulse, attention-set pulse at the
// milestones, and the held attention flag. A set beats a clear.
module cg_attn
    import cg_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       accept,
    input  logic       reject,
    input  logic [2:0] cmd_class,
    input  logic       busy,
    input  logic [2:0] cur_cls,
    input  logic       op_done,
    input  logic       any_err,
    input  logic       ssc_evt,
    input  logic       endpt_evt,
    input  logic       hit_err,
    input  logic       hit_ssc,
    input  logic       hit_ep,
    input  logic       attn_clr,
    output logic       go_clr,
    output logic       attn_set,
    output logic       attn
);
    logic end_attn;
    logic set_now;

    // Milestone detection.
    always_comb begin
        end_attn = busy && op_done &&
                   (cur_cls == CLS_MOTION || hit_err || any_err ||
                    hit_ssc || ssc_evt || hit_ep || endpt_evt);
        set_now  = reject || (accept && cmd_class == CLS_REWIND) || end_attn;
    end

    // Registered pulses and held flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            go_clr   <= 1'b0;
            attn_set <= 1'b0;
            attn     <= 1'b0;
        end else begin
            go_clr   <= reject;
            attn_set <= set_now;
            if (set_now)
                attn <= 1'b1;
            else if (attn_clr)
                attn <= 1'b0;
        end
    end
endmodule

// File: rtl/cg_abort.sv
// Transfer abort logic: the exception line, the end-of-block flag and the
// write-terminate flag. The flags hold until the next accepted command.
module cg_abort
    import cg_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       accept,
    input  logic       reject,
    input  logic [2:0] cmd_class,
    input  logic       busy,
    input  logic [2:0] cur_cls,
    input  phase_e     phase,
    input  logic       any_err,
    input  logic       cb_err,
    input  logic       dt_err,
    input  logic       abort_en,
    output logic       exc,
    output logic       eob,
    output logic       wr_end
);
    logic xfer_busy;
    logic run_abort;

    // Abort conditions during an active transfer.
    always_comb begin
        xfer_busy = busy && is_data(cur_cls);
        exc       = xfer_busy && any_err;
        run_abort = xfer_busy &&
                    ((phase == PH_INIT && any_err) ||
                     (phase == PH_XFER && (cb_err || (abort_en && dt_err))));
    end

    // Sticky end-of-block and write-terminate flags.
    always_ff @(posedge clk) begin
        if (!rst_n || accept) begin
            eob    <= 1'b0;
            wr_end <= 1'b0;
        end else begin
            if (run_abort || (reject && is_data(cmd_class)))
                eob <= 1'b1;
            if (run_abort && cur_cls == CLS_WRITE)
                wr_end <= 1'b1;
        end
    end
endmodule

// File: rtl/cmd_guard.sv
// Top of the command guard. It checks each loaded command against the
// composite error and runs attention and transfer-abort signalling.
// Error detection happens elsewhere; err_bits arrive already held.
module cmd_guard
    import cg_pkg::*;
#(
    parameter int          ERR_W   = 16,
    parameter logic [15:0] CB_MASK = 16'h000F,
    parameter logic [15:0] DT_MASK = 16'h00F0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [ERR_W-1:0] err_bits,
    input  logic             cmd_load,
    input  logic             cmd_go,
    input  logic [2:0]       cmd_class,
    input  logic             abort_en,
    input  logic             run_start,
    input  logic             op_done,
    input  logic             ssc_evt,
    input  logic             endpt_evt,
    input  logic             attn_clr,
    output logic             busy,
    output logic             go_clr,
    output logic             attn_set,
    output logic             attn,
    output logic             exc,
    output logic             eob,
    output logic             wr_end
);
    logic       any_err, cb_err, dt_err;
    logic       accept, reject;
    logic [2:0] cur_cls;
    phase_e     phase;
    logic       hit_err, hit_ssc, hit_ep;

    cg_err_merge #(.ERR_W(ERR_W), .CB_MASK(CB_MASK), .DT_MASK(DT_MASK)) u_merge (
        .err_bits(err_bits), .any_err(any_err), .cb_err(cb_err), .dt_err(dt_err)
    );

    cg_op_track u_track (
        .clk(clk), .rst_n(rst_n), .cmd_load(cmd_load), .cmd_go(cmd_go),
        .cmd_class(cmd_class), .any_err(any_err), .run_start(run_start),
        .op_done(op_done), .ssc_evt(ssc_evt), .endpt_evt(endpt_evt),
        .accept(accept), .reject(reject), .busy(busy), .cur_cls(cur_cls),
        .phase(phase), .hit_err(hit_err), .hit_ssc(hit_ssc), .hit_ep(hit_ep)
    );

    cg_attn u_attn (
        .clk(clk), .rst_n(rst_n), .accept(accept), .reject(reject),
        .cmd_class(cmd_class), .busy(busy), .cur_cls(cur_cls),
        .op_done(op_done), .any_err(any_err), .ssc_evt(ssc_evt),
        .endpt_evt(endpt_evt), .hit_err(hit_err), .hit_ssc(hit_ssc),
        .hit_ep(hit_ep), .attn_clr(attn_clr), .go_clr(go_clr),
        .attn_set(attn_set), .attn(attn)
    );

    cg_abort u_abort (
        .clk(clk), .rst_n(rst_n), .accept(accept), .reject(reject),
        .cmd_class(cmd_class), .busy(busy), .cur_cls(cur_cls), .phase(phase),
        .any_err(any_err), .cb_err(cb_err), .dt_err(dt_err),
        .abort_en(abort_en), .exc(exc), .eob(eob), .wr_end(wr_end)
    );
endmodule

// File: rtl/cmd_guard_chk.sv
// Checker for cmd_guard, attached by bind. Relates ports over time.
module cmd_guard_chk #(
    parameter int ERR_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic [ERR_W-1:0] err_bits,
    input logic             cmd_load,
    input logic             cmd_go,
    input logic             attn_clr,
    input logic             busy,
    input logic             go_clr,
    input logic             attn_set,
    input logic             attn,
    input logic             exc,
    input logic             eob,
    input logic             wr_end
);
    a_r1_refuse_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_load && cmd_go && !busy && |err_bits) |=> (!busy && go_clr));

    a_r2_accept_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_load && cmd_go && !busy && !(|err_bits)) |=> busy);

    a_r3_goclr_attn: assert property (@(posedge clk) disable iff (!rst_n)
        go_clr |-> (attn_set && attn));

    a_r6_exc_busy: assert property (@(posedge clk) disable iff (!rst_n)
        exc |-> (busy && |err_bits));

    a_r9_wrend_eob: assert property (@(posedge clk) disable iff (!rst_n)
        wr_end |-> eob);

    a_r10_attn_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (attn && !attn_clr) |=> attn);
endmodule

bind cmd_guard cmd_guard_chk #(.ERR_W(ERR_W)) u_cmd_guard_chk (
    .clk(clk), .rst_n(rst_n), .err_bits(err_bits), .cmd_load(cmd_load),
    .cmd_go(cmd_go), .attn_clr(attn_clr), .busy(busy), .go_clr(go_clr),
    .attn_set(attn_set), .attn(attn), .exc(exc), .eob(eob), .wr_end(wr_end)
);

// File: tb/cmd_guard_bench.sv
// Bench for cmd_guard: a behavioural reference model compared every cycle.
module cmd_guard_bench;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [15:0] err_bits;
    logic        cmd_load, cmd_go, abort_en, run_start, op_done;
    logic        ssc_evt, endpt_evt, attn_clr;
    logic [2:0]  cmd_class;
    logic        busy, go_clr, attn_set, attn, exc, eob, wr_end;

    int checks = 0;
    int errors = 0;
    int cyc    = 0;

    // Reference state.
    int m_busy, m_cls, m_xfer, m_he, m_hs, m_hp;
    int m_goclr, m_aset, m_attn, m_eob, m_wend;

    always #10 clk = ~clk;

    cmd_guard u_cmd_guard (
        .clk(clk), .rst_n(rst_n), .err_bits(err_bits), .cmd_load(cmd_load),
        .cmd_go(cmd_go), .cmd_class(cmd_class), .abort_en(abort_en),
        .run_start(run_start), .op_done(op_done), .ssc_evt(ssc_evt),
        .endpt_evt(endpt_evt), .attn_clr(attn_clr), .busy(busy),
        .go_clr(go_clr), .attn_set(attn_set), .attn(attn), .exc(exc),
        .eob(eob), .wr_end(wr_end)
    );

    task automatic chk(input string req, input string nm, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s cycle %0d actual %0d expected %0d", req, nm, cyc, act, exp);
        end
    endtask

    // One clock: the model computes its next state from the current inputs,
    // then the outputs are compared at the falling edge.
    task automatic tick();
        int err, cb, dt, dat, acc, rej, ab, set;
        int n_busy, n_cls, n_xfer, n_he, n_hs, n_hp, n_goclr, n_aset, n_attn, n_eob, n_wend;
        err = (err_bits != 0);
        cb  = (err_bits[3:0] != 0);
        dt  = (err_bits[7:4] != 0);
        dat = (m_cls == 3 || m_cls == 4);
        acc = cmd_load && cmd_go && !m_busy && !err;
        rej = cmd_load && cmd_go && !m_busy && err;
        ab  = m_busy && dat && ((!m_xfer && err) || (m_xfer && (cb || (abort_en && dt))));
        n_busy = m_busy; n_cls = m_cls; n_xfer = m_xfer;
        n_he = m_he; n_hs = m_hs; n_hp = m_hp;
        n_eob = m_eob; n_wend = m_wend;
        if (acc) begin
            n_busy = 1; n_cls = cmd_class; n_xfer = 0;
            n_he = 0; n_hs = 0; n_hp = 0; n_eob = 0; n_wend = 0;
        end else begin
            if (m_busy) begin
                if (op_done) n_busy = 0;
                if (run_start) n_xfer = 1;
                if (err) n_he = 1;
                if (ssc_evt) n_hs = 1;
                if (endpt_evt) n_hp = 1;
            end
            if (ab || (rej && (cmd_class == 3 || cmd_class == 4))) n_eob = 1;
            if (ab && m_cls == 4) n_wend = 1;
        end
        set = rej || (acc && cmd_class == 2) ||
              (m_busy && op_done && (m_cls == 1 || m_he || err || m_hs || ssc_evt || m_hp || endpt_evt));
        n_goclr = rej;
        n_aset  = set;
        n_attn  = set ? 1 : (attn_clr ? 0 : m_attn);
        if (!rst_n) begin
            n_busy = 0; n_cls = 0; n_xfer = 0; n_he = 0; n_hs = 0; n_hp = 0;
            n_goclr = 0; n_aset = 0; n_attn = 0; n_eob = 0; n_wend = 0;
        end
        @(posedge clk);
        m_busy = n_busy; m_cls = n_cls; m_xfer = n_xfer; m_he = n_he;
        m_hs = n_hs; m_hp = n_hp; m_goclr = n_goclr; m_aset = n_aset;
        m_attn = n_attn; m_eob = n_eob; m_wend = n_wend;
        cyc++;
        @(negedge clk);
        chk("R2", "busy", busy, m_busy);
        chk("R1", "go_clr", go_clr, m_goclr);
        chk("R4", "attn_set", attn_set, m_aset);
        chk("R10", "attn", attn, m_attn);
        chk("R6", "exc", exc, m_busy && (m_cls == 3 || m_cls == 4) && (err_bits != 0));
        chk("R8", "eob", eob, m_eob);
        chk("R9", "wr_end", wr_end, m_wend);
    endtask

    task automatic idle_inputs();
        cmd_load = 0; cmd_go = 0; run_start = 0; op_done = 0;
        ssc_evt = 0; endpt_evt = 0; attn_clr = 0;
    endtask

    task automatic load(input int cls, input int go);
        cmd_load = 1; cmd_go = go[0]; cmd_class = cls[2:0];
        tick();
        cmd_load = 0; cmd_go = 0;
    endtask

    task automatic pulse_done();
        op_done = 1; tick(); op_done = 0;
    endtask

    task automatic clear_attn();
        attn_clr = 1; tick(); attn_clr = 0;
    endtask

    // Watchdog.
    initial begin
        #2000000;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        rst_n = 0; err_bits = 0; abort_en = 0; cmd_class = 0;
        idle_inputs();
        m_busy = 0; m_cls = 0; m_xfer = 0; m_he = 0; m_hs = 0; m_hp = 0;
        m_goclr = 0; m_aset = 0; m_attn = 0; m_eob = 0; m_wend = 0;
        repeat (3) tick();          // reset state checks
        rst_n = 1; tick();

        // R2 / R4: clean control op, no attention; then motion op with attention.
        load(0, 1); repeat (3) tick(); pulse_done(); tick();
        load(1, 1); repeat (2) tick(); pulse_done(); tick(); clear_attn();
        // Load without GO does nothing.
        load(3, 0); tick();
        // R4: rewind raises attention at acceptance.
        load(2, 1); tick(); clear_attn(); pulse_done(); tick();

        // R1 / R3 / R7: refused read with high-order error only.
        err_bits = 16'h0100; load(3, 1); tick();
        // R10: set wins over a clear in the same cycle.
        cmd_load = 1; cmd_go = 1; cmd_class = 0; attn_clr = 1; tick(); idle_inputs();
        clear_attn(); err_bits = 0; tick();

        // R7: error in initiation phase of a read.
        load(3, 1); tick(); err_bits = 16'h0800; repeat (2) tick();
        err_bits = 0; run_start = 1; tick(); run_start = 0; repeat (2) tick();
        pulse_done(); tick(); clear_attn();          // R5 error seen -> attention

        // R8: data error without abort enable, then class-B error.
        load(3, 1); run_start = 1; tick(); run_start = 0;
        err_bits = 16'h0020; repeat (2) tick();       // no eob
        err_bits = 16'h2000; tick();                  // bits 15:8: no eob
        err_bits = 16'h0002; tick();                  // class-B: eob
        err_bits = 0;
        // R9: read keeps busy after eob until done.
        repeat (3) tick(); pulse_done(); tick(); clear_attn();

        // R8 / R9: write with abort enable and data error -> eob and wr_end.
        abort_en = 1;
        load(4, 1); run_start = 1; tick(); run_start = 0; tick();
        err_bits = 16'h0040; tick(); err_bits = 0; repeat (2) tick();
        // R10: load while busy is ignored.
        load(1, 1); tick();
        pulse_done(); tick(); clear_attn();
        abort_en = 0;

        // R5: slave change and end point during clean ops.
        load(0, 1); ssc_evt = 1; tick(); ssc_evt = 0; tick(); pulse_done(); tick(); clear_attn();
        load(0, 1); tick(); endpt_evt = 1; op_done = 1; tick(); idle_inputs(); tick(); clear_attn();
        // R5: error only in the done cycle.
        load(0, 1); tick(); err_bits = 16'h0001; op_done = 1; tick(); idle_inputs();
        err_bits = 0; tick(); clear_attn();

        // R6: exception follows the error level immediately on a write.
        load(4, 1); tick(); err_bits = 16'h0400; tick(); err_bits = 0; tick();
        pulse_done(); tick(); clear_attn();
        // R7: refused write sets eob.
        err_bits = 16'h0010; load(4, 1); err_bits = 0; tick(); clear_attn();
        // Next accepted command clears eob (R8).
        load(0, 1); tick(); pulse_done(); tick();

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule